// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An 8-bit general-purpose I/O port with per-pin controls for the output driver, open-drain behaviour, interrupt masking and interrupt edge selection. A simple register interface writes and reads the configuration. The block drives a per-pin output value and output-enable toward the pads. It samples the pad levels through a synchronizer, and a read of the data address returns those sampled levels. Selected pins can be handed to an alternate-function peripheral, such as a serial peripheral interface, which then owns the pin's output value and output enable.

Interrupts are edge-triggered. Each pin selects the rising or the falling edge. Pins outside the shared group each have their own pending flag. Pins inside the shared group feed a single shared pending flag. That flag re-arms only after every enabled member of the group has returned to its inactive level. All pending flags clear by a write-one-to-clear acknowledge, and the interrupt output is their OR. The pull-up, threshold and sink-strength bits are only stored. They appear on configuration outputs and have no effect inside the block.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Register address 1 holds the output-enable bits and address 0 the output data. On a GPIO pin with open-drain off, pad_oe follows the output-enable bit and pad_out follows the data bit. No pad is enabled unless its output-enable bit or its alternate function enables it.
- R2: A read of address 0 returns the pad levels through a two-stage synchronizer: a level change becomes visible on the second rising clock edge after it. The read never returns the stored data value.
- R3: Address 4 selects the edge per pin: bit 0 means rising and bit 1 means falling. A qualifying edge on an enabled, unshared pin sets that pin's bit in the pending register (address 9) on the third clock edge after the pad changes. An edge of the other direction sets nothing.
- R4: Address 2 selects open-drain per pin. In open-drain mode, a data bit of 1 turns the driver off (pad_oe low) and a data bit of 0 drives low (pad_oe high, pad_out low). Such a pin is never driven high.
- R5: A pin configured as an output, with its interrupt enabled, raises its own pending flag when the block drives the qualifying level.
- R6: Pins in SHARED_MASK (default pins 7..4) set one shared pending flag, which is bit 0 of address 10. The flag is set only by a qualifying edge that occurs while no other enabled shared pin is at its active level. An edge on a second pin while the first is still active sets nothing.
- R7: Address 3 holds the interrupt-enable bits. A pin whose bit is clear never sets any pending flag.
- R8: Address 5 holds the alternate-function use bits. These bits are stored only for pins in ALT_MASK (default pins 6..3) and read back as 0 elsewhere. While a use bit is set, pad_out and pad_oe of that pin come from alt_out and alt_oe.
- R9: Writing 1s to address 9, or to bit 0 of address 10, clears the matching pending flags. A flag that is not written stays set. irq is high exactly while any pending flag is set.
- R10: Addresses 6, 7 and 8 store the pull-up, threshold and sink-strength bits. They read back unchanged, appear on cfg_pullup, cfg_ttl and cfg_hisink, and do not change pad_oe.
- R11: After reset, every register reads 0, no pad is enabled and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pin_in | input | 8 | Pad levels, asynchronous |
| pad_out | output | 8 | Output value toward the pads |
| pad_oe | output | 8 | Output driver enable toward the pads |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| cfg_pullup | output | 8 | Stored pull-up select bits |
| cfg_ttl | output | 8 | Stored input threshold select bits |
| cfg_hisink | output | 8 | Stored sink-strength select bits |
| irq | output | 1 | OR of all pending flags |

## Verification
Edge detection is driven with a rising pulse and a falling pulse under each polarity setting. This separates correct edge selection from inverted or level-sensitive detection. The shared line is driven with overlapping pulses on two member pins and then with the same pulses separated. This shows that re-arming waits for all members to go inactive, rather than firing on every member edge. The pad model feeds driven pins back to the inputs, so a self-triggered interrupt and the open-drain high-impedance state are both seen on the real input path. Register reads of address 0 taken one and two cycles after a pad change confirm the synchronizer depth, and confirm that the read reflects pin levels and not the stored data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
   localparam logic [ADDR_W-1:0] A_OE    = 4'd1;
   localparam logic [ADDR_W-1:0] A_OD    = 4'd2;
   localparam logic [ADDR_W-1:0] A_IEN   = 4'd3;
   localparam logic [ADDR_W-1:0] A_IPOL  = 4'd4;
   localparam logic [ADDR_W-1:0] A_ALT   = 4'd5;
   localparam logic [ADDR_W-1:0] A_PULL  = 4'd6;
   localparam logic [ADDR_W-1:0] A_THR   = 4'd7;
   localparam logic [ADDR_W-1:0] A_SINK  = 4'd8;
   localparam logic [ADDR_W-1:0] A_PEND  = 4'd9;
   localparam logic [ADDR_W-1:0] A_SPEND = 4'd10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int           W        = 8,
   parameter logic [W-1:0] ALT_MASK = '0
) (
   input  logic [W-1:0] data_q,
   input  logic [W-1:0] oe_q,
   input  logic [W-1:0] od_q,
   input  logic [W-1:0] alt_q,
   input  logic [W-1:0] alt_out,
   input  logic [W-1:0] alt_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);
   logic [W-1:0] gp_out, gp_oe;

   // open drain: a 1 releases the pad, a 0 pulls it low
   assign gp_oe  = oe_q & ~(od_q & data_q);
   assign gp_out = data_q & ~od_q;

   generate
      if (ALT_MASK == '0) begin : g_plain
         assign pad_out = gp_out;
         assign pad_oe  = gp_oe;
      end else begin : g_alt
         logic [W-1:0] sel;
         assign sel     = alt_q & ALT_MASK;
         assign pad_out = (sel & alt_out) | (~sel & gp_out);
         assign pad_oe  = (sel & alt_oe)  | (~sel & gp_oe);
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int           W           = 8,
   parameter logic [W-1:0] SHARED_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_sync,
   input  logic [W-1:0] ien,
   input  logic [W-1:0] ipol,
   input  logic [W-1:0] clr,
   input  logic         clr_shared,
   output logic [W-1:0] pend,
   output logic         spend
);
   logic [W-1:0] s_d, rise, fall, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_d <= '0;
      else        s_d <= pin_sync;
   end

   // edges are taken from raw samples so a polarity change alone never fires
   assign rise = pin_sync & ~s_d;
   assign fall = ~pin_sync & s_d;
   assign hit  = ((ipol & fall) | (~ipol & rise)) & ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (hit | (pend & ~clr)) & ~SHARED_MASK;
   end

   generate
      if (SHARED_MASK != '0) begin : g_shared
         logic active_prev, set_shared;
         // any enabled member at its active level in the previous sample
         assign active_prev = |((s_d ^ ipol) & ien & SHARED_MASK);
         assign set_shared  = (|(hit & SHARED_MASK)) & ~active_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) spend <= 1'b0;
            else        spend <= set_shared | (spend & ~clr_shared);
         end
      end else begin : g_noshared
         assign spend = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int                NPINS       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NPINS-1:0]  SHARED_MASK = 8'hF0,
   parameter logic [NPINS-1:0]  ALT_MASK    = 8'h78
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NPINS-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NPINS-1:0]  rd_data,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  cfg_pullup,
   output logic [NPINS-1:0]  cfg_ttl,
   output logic [NPINS-1:0]  cfg_hisink,
   output logic              irq
);
   localparam int PAD_W = NPINS - 1;

   generate
      if (NPINS < 2 || NPINS > 32) begin : g_bad_width
         $error("NPINS must lie in 2..32");
      end
   endgenerate

   logic [NPINS-1:0] data_q, oe_q, od_q, ien_q, ipol_q, alt_q;
   logic [NPINS-1:0] pull_q, thr_q, sink_q;
   logic [NPINS-1:0] pin_sync, pend, pend_clr;
   logic             spend, spend_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0; oe_q <= '0; od_q <= '0; ien_q <= '0; ipol_q <= '0;
         alt_q <= '0; pull_q <= '0; thr_q <= '0; sink_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_DATA: data_q <= wr_data;
            A_OE:   oe_q   <= wr_data;
            A_OD:   od_q   <= wr_data;
            A_IEN:  ien_q  <= wr_data;
            A_IPOL: ipol_q <= wr_data;
            A_ALT:  alt_q  <= wr_data & ALT_MASK;
            A_PULL: pull_q <= wr_data;
            A_THR:  thr_q  <= wr_data;
            A_SINK: sink_q <= wr_data;
            default: ;
         endcase
      end
   end

   assign pend_clr  = (wr_en && wr_addr == A_PEND) ? wr_data : '0;
   assign spend_clr = wr_en && (wr_addr == A_SPEND) && wr_data[0];

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   gpio_pad_mux #(.W(NPINS), .ALT_MASK(ALT_MASK)) u_mux (
      .data_q(data_q), .oe_q(oe_q), .od_q(od_q), .alt_q(alt_q),
      .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   gpio_irq_unit #(.W(NPINS), .SHARED_MASK(SHARED_MASK)) u_irq (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .ien(ien_q), .ipol(ipol_q),
      .clr(pend_clr), .clr_shared(spend_clr), .pend(pend), .spend(spend)
   );

   always_comb begin
      case (rd_addr)
         A_DATA:  rd_data = pin_sync;
         A_OE:    rd_data = oe_q;
         A_OD:    rd_data = od_q;
         A_IEN:   rd_data = ien_q;
         A_IPOL:  rd_data = ipol_q;
         A_ALT:   rd_data = alt_q;
         A_PULL:  rd_data = pull_q;
         A_THR:   rd_data = thr_q;
         A_SINK:  rd_data = sink_q;
         A_PEND:  rd_data = pend;
         A_SPEND: rd_data = {{PAD_W{1'b0}}, spend};
         default: rd_data = '0;
      endcase
   end

   assign cfg_pullup = pull_q;
   assign cfg_ttl    = thr_q;
   assign cfg_hisink = sink_q;
   assign irq        = (|pend) | spend;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int               NPINS       = 8,
   parameter logic [NPINS-1:0] SHARED_MASK = '0,
   parameter logic [NPINS-1:0] ALT_MASK    = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [NPINS-1:0] pad_out,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] oe_q,
   input logic [NPINS-1:0] od_q,
   input logic [NPINS-1:0] ien_q,
   input logic [NPINS-1:0] ipol_q,
   input logic [NPINS-1:0] alt_q,
   input logic [NPINS-1:0] pin_sync,
   input logic [NPINS-1:0] pend,
   input logic             spend,
   input logic             irq
);
   // R1: a pad is enabled only by its enable bit or its alternate function
   assert_oe_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~oe_q & ~alt_q) == '0);

   // R4: a GPIO pin in open-drain mode is never driven high
   assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_out & od_q & ~alt_q) == '0);

   // R7: a pending bit only rises on a pin that was enabled
   assert_pend_needs_ien_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend)) & ~$past(ien_q)) == '0);

   // R6: shared flag rises only if no enabled member was active before the edge
   assert_shared_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spend) && $stable(ipol_q) && $stable(ien_q)) |->
      ((($past(pin_sync, 2) ^ ipol_q) & ien_q & SHARED_MASK) == '0));

   // R8: use bits exist only on pins with an alternate function
   assert_alt_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_q & ~ALT_MASK) == '0);

   // R9: the interrupt only drops after an acknowledge write
   assert_irq_fall_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en));
endmodule

bind gpio_port_ctrl gpio_port_chk #(
   .NPINS(NPINS), .SHARED_MASK(SHARED_MASK), .ALT_MASK(ALT_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pad_out(pad_out), .pad_oe(pad_oe),
   .oe_q(oe_q), .od_q(od_q), .ien_q(ien_q), .ipol_q(ipol_q), .alt_q(alt_q),
   .pin_sync(pin_sync), .pend(pend), .spend(spend), .irq(irq)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [7:0] pin_in, pad_out, pad_oe;
   logic [7:0] alt_out = '0, alt_oe = '0, ext = '0;
   logic [7:0] cfg_pullup, cfg_ttl, cfg_hisink;
   logic       irq;
   int         errors = 0, checks = 0;
   logic [7:0] v;

   always #4 clk = ~clk;

   // pad model: driven pads follow the block, released pads follow the outside world
   assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe), .cfg_pullup(cfg_pullup),
      .cfg_ttl(cfg_ttl), .cfg_hisink(cfg_hisink), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] r);
      rd_addr = a; #1; r = rd_data;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; ext = '0; alt_out = '0; alt_oe = '0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      for (int a = 0; a < 11; a++) begin
         rd(a[3:0], v); chk("R11 register after reset", v, 8'h00);
      end
      chk("R11 pad_oe after reset", pad_oe, 8'h00);
      chk("R11 irq after reset", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_push_pull();
      do_reset();
      wr(4'd1, 8'h03); wr(4'd0, 8'h81);
      chk("R1 pad_oe follows enable", pad_oe, 8'h03);
      chk("R1 pad_out follows data", pad_out, 8'h81);
      wait_edges(3); rd(4'd0, v);
      chk("R2 read shows driven pins", v, 8'h01);
   endtask

   task automatic t_readback();
      do_reset();
      wr(4'd0, 8'h0F);
      ext = 8'hA5;
      wait_edges(1); rd(4'd0, v);
      chk("R2 one edge after change", v, 8'h00);
      wait_edges(1); rd(4'd0, v);
      chk("R2 two edges after change", v, 8'hA5);
   endtask

   task automatic t_edges();
      do_reset();
      wr(4'd3, 8'h01);
      @(negedge clk); ext[0] = 1'b1;
      wait_edges(2); chk("R3 rise not yet pending", {7'd0, irq}, 8'h00);
      wait_edges(1); chk("R3 rise sets irq", {7'd0, irq}, 8'h01);
      rd(4'd9, v); chk("R3 pending bit 0", v, 8'h01);
      wr(4'd9, 8'h01); chk("R9 ack clears irq", {7'd0, irq}, 8'h00);
      @(negedge clk); ext[0] = 1'b0;
      wait_edges(4); chk("R3 fall ignored on rising polarity", {7'd0, irq}, 8'h00);
      wr(4'd4, 8'h01);
      @(negedge clk); ext[0] = 1'b1;
      wait_edges(4); chk("R3 rise ignored on falling polarity", {7'd0, irq}, 8'h00);
      @(negedge clk); ext[0] = 1'b0;
      wait_edges(3); chk("R3 fall sets irq", {7'd0, irq}, 8'h01);
      wr(4'd9, 8'h00); rd(4'd9, v); chk("R9 zero write keeps pending", v, 8'h01);
   endtask

   task automatic t_masked();
      do_reset();
      @(negedge clk); ext[1] = 1'b1;
      wait_edges(4); rd(4'd9, v);
      chk("R7 disabled pin sets nothing", v, 8'h00);
      chk("R7 irq stays low", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_open_drain();
      do_reset();
      ext[2] = 1'b1;
      wr(4'd2, 8'h04); wr(4'd1, 8'h04); wr(4'd0, 8'h04);
      chk("R4 data 1 releases pad", pad_oe & 8'h04, 8'h00);
      wr(4'd0, 8'h00);
      chk("R4 data 0 drives pad", pad_oe & 8'h04, 8'h04);
      chk("R4 data 0 drives low", pad_out & 8'h04, 8'h00);
   endtask

   task automatic t_self_trigger();
      do_reset();
      wr(4'd1, 8'h02); wr(4'd3, 8'h02); wr(4'd0, 8'h02);
      wait_edges(2); chk("R5 self edge not yet", {7'd0, irq}, 8'h00);
      wait_edges(1); rd(4'd9, v);
      chk("R5 output pin triggers itself", v, 8'h02);
   endtask

   task automatic t_shared();
      do_reset();
      wr(4'd3, 8'h30);
      @(negedge clk); ext[4] = 1'b1;
      wait_edges(3); rd(4'd10, v); chk("R6 first member sets shared", v, 8'h01);
      rd(4'd9, v); chk("R6 no dedicated bit for member", v, 8'h00);
      wr(4'd10, 8'h01); chk("R9 shared ack clears irq", {7'd0, irq}, 8'h00);
      @(negedge clk); ext[5] = 1'b1;
      wait_edges(4); chk("R6 overlap does not refire", {7'd0, irq}, 8'h00);
      @(negedge clk); ext[5:4] = 2'b00;
      wait_edges(4);
      @(negedge clk); ext[5] = 1'b1;
      wait_edges(3); rd(4'd10, v); chk("R6 re-armed after all idle", v, 8'h01);
   endtask

   task automatic t_alt();
      do_reset();
      wr(4'd5, 8'hFF); rd(4'd5, v); chk("R8 use bits masked", v, 8'h78);
      alt_oe = 8'hFF; alt_out = 8'h28; #1;
      chk("R8 peripheral owns enable", pad_oe, 8'h78);
      chk("R8 peripheral owns data", pad_out & 8'h78, 8'h28);
      wr(4'd5, 8'h00);
      chk("R8 GPIO again after clear", pad_oe, 8'h00);
   endtask

   task automatic t_cfg();
      do_reset();
      wr(4'd6, 8'h11); wr(4'd7, 8'h22); wr(4'd8, 8'h44);
      rd(4'd7, v); chk("R10 threshold readback", v, 8'h22);
      chk("R10 pull-up output", cfg_pullup, 8'h11);
      chk("R10 threshold output", cfg_ttl, 8'h22);
      chk("R10 sink output", cfg_hisink, 8'h44);
      chk("R10 no effect on drivers", pad_oe, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_push_pull();
      t_readback();
      t_edges();
      t_masked();
      t_open_drain();
      t_self_trigger();
      t_shared();
      t_alt();
      t_cfg();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule